// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner

This block sits between the raw clock and data pins of a two-wire serial bus and the slave controller behind it. It brings both lines into the system clock domain through a two-stage synchronizer and then passes them through a digital spike filter. A change on a line is accepted only after it has held for more than a programmable number of system-clock cycles. From the clean levels it derives one-cycle strobes for clock rising and falling edges, and one-cycle pulses for a start condition (data falls while clock is high) and a stop condition (data rises while clock is high). It also keeps a bus-idle flag that a stop sets and a start clears.

On the transmit side, the controller asks for the data line to be pulled low through `sda_drive_req`. The block forwards this request to the pad as `sda_pull`. After every filtered clock falling edge it keeps the pad state frozen for a parameterised hold window. This prevents a data change from landing near the clock edge, where other devices could see it as a false start or stop. Both the filter width (`SPIKE_CYC`) and the hold window (`HOLD_CYC`) are counted in system-clock cycles. At 250 MHz, the defaults of 13 and 75 cover 50 ns of spike rejection and 300 ns of hold.

Top module: `twi_bus_frontend`

## Requirements
- R1: While reset is held and right after it, `scl_level`, `sda_level` and `bus_idle` are 1, and `scl_rise`, `scl_fall`, `start_pulse`, `stop_pulse` and `sda_pull` are 0.
- R2: A pin excursion that the clock samples on SPIKE_CYC or fewer consecutive edges leaves `scl_level`/`sda_level` unchanged and raises no strobe or pulse.
- R3: A pin level that the clock samples on at least SPIKE_CYC+1 consecutive edges is adopted. The new filtered level is present after the (SPIKE_CYC+3)-th edge that samples it.
- R4: `scl_rise` (`scl_fall`) is 1 for exactly the one cycle in which `scl_level` first shows 1 (0).
- R5: When `sda_level` falls while `scl_level` is 1, `start_pulse` is 1 for exactly the one cycle in which `sda_level` first shows 0.
- R6: When `sda_level` rises while `scl_level` is 1, `stop_pulse` is 1 for exactly the one cycle in which `sda_level` first shows 1.
- R7: Data changes made while `scl_level` is 0 produce no start or stop pulse.
- R8: `bus_idle` becomes 0 one cycle after a start pulse and 1 one cycle after a stop pulse. Otherwise it keeps its value.
- R9: After the cycle in which `scl_fall` is 1, `sda_pull` keeps its value across the next HOLD_CYC+1 clock edges, whatever `sda_drive_req` does.
- R10: Outside that hold window, `sda_pull` takes the value of `sda_drive_req` on the next clock edge (1 means pull the data line low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_pin | input | 1 | Raw bus clock line |
| sda_pin | input | 1 | Raw bus data line |
| sda_drive_req | input | 1 | Controller request to pull data low |
| scl_level | output | 1 | Filtered clock level |
| sda_level | output | 1 | Filtered data level |
| scl_rise | output | 1 | One-cycle strobe on filtered clock rise |
| scl_fall | output | 1 | One-cycle strobe on filtered clock fall |
| start_pulse | output | 1 | One-cycle start condition pulse |
| stop_pulse | output | 1 | One-cycle stop condition pulse |
| bus_idle | output | 1 | Bus free since the last stop |
| sda_pull | output | 1 | Hold-delayed data pull-down to the pad |

## Verification
A pin change made just before a clock edge reaches `scl_level`/`sda_level` on the SPIKE_CYC+3-th edge. The edge strobes and the start/stop pulses appear in that same cycle, and `bus_idle` follows one edge later. The bench drives pins on falling clock edges and counts falling edges until the filtered output moves. It compares that count with SPIKE_CYC+3, and also checks the pulse one cycle later. Pulse widths from 1 to SPIKE_CYC+3 are swept on both lines, with acceptance expected exactly from SPIKE_CYC+1 upward. For the hold window, `sda_drive_req` is moved d cycles after the `scl_fall` strobe, for every d from 0 to HOLD_CYC+3. The pad change is expected to be seen max(d, HOLD_CYC+1)+1 falling edges after the strobe.

// File: rtl/twi_bus_frontend.sv
module twi_bus_frontend #(
  parameter int SPIKE_CYC = 13,
  parameter int HOLD_CYC  = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  input  logic sda_drive_req,
  output logic scl_level,
  output logic sda_level,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_pulse,
  output logic stop_pulse,
  output logic bus_idle,
  output logic sda_pull
);
  localparam int SW = $clog2(SPIKE_CYC + 2);
  localparam int HW = $clog2(HOLD_CYC + 2);

  logic [1:0] raw, filt, prev;
  logic [HW-1:0] hold_cnt;

  assign raw = {sda_pin, scl_pin};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic meta, sync, level;
    logic [SW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta  <= 1'b1;
        sync  <= 1'b1;
        level <= 1'b1;
        cnt   <= '0;
      end else begin
        meta <= raw[i];
        sync <= meta;
        if (sync == level) begin
          cnt <= '0;
        end else if (cnt == SW'(SPIKE_CYC)) begin
          level <= sync;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign filt[i] = level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 2'b11;
    else        prev <= filt;
  end

  assign scl_level   = filt[0];
  assign sda_level   = filt[1];
  assign scl_rise    = filt[0] & ~prev[0];
  assign scl_fall    = ~filt[0] & prev[0];
  assign start_pulse = filt[0] & prev[0] & prev[1] & ~filt[1];
  assign stop_pulse  = filt[0] & prev[0] & ~prev[1] & filt[1];

  always_ff @(posedge clk) begin
    if (!rst_n)           bus_idle <= 1'b1;
    else if (start_pulse) bus_idle <= 1'b0;
    else if (stop_pulse)  bus_idle <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      sda_pull <= 1'b0;
    end else begin
      if (scl_fall)            hold_cnt <= HW'(HOLD_CYC);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (!scl_fall && hold_cnt == '0) sda_pull <= sda_drive_req;
    end
  end
endmodule

// File: rtl/twi_bus_frontend_chk.sv
module twi_bus_frontend_chk #(
  parameter int HOLD_CYC = 75
) (
  input logic clk,
  input logic rst_n,
  input logic sda_drive_req,
  input logic scl_level,
  input logic sda_level,
  input logic scl_fall,
  input logic start_pulse,
  input logic stop_pulse,
  input logic bus_idle,
  input logic sda_pull
);
  localparam int CAP = HOLD_CYC + 2;
  localparam int AW  = $clog2(CAP + 1);

  logic [AW-1:0] fall_age;

  always_ff @(posedge clk) begin
    if (!rst_n)                   fall_age <= AW'(CAP);
    else if (scl_fall)            fall_age <= AW'(1);
    else if (fall_age < AW'(CAP)) fall_age <= fall_age + 1'b1;
  end

  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  p_start_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (scl_level && !sda_level));
  p_stop_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);
  p_stop_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> (scl_level && sda_level));
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !bus_idle);
  p_idle_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> bus_idle);
  p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_pulse && !stop_pulse) |=> $stable(bus_idle));
  p_hold_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_age >= AW'(1) && fall_age <= AW'(HOLD_CYC + 1)) |-> $stable(sda_pull));
  p_follow_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_age >= AW'(HOLD_CYC + 1) && !scl_fall) |=> (sda_pull == $past(sda_drive_req)));
endmodule

bind twi_bus_frontend twi_bus_frontend_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_drive_req(sda_drive_req),
  .scl_level(scl_level), .sda_level(sda_level), .scl_fall(scl_fall),
  .start_pulse(start_pulse), .stop_pulse(stop_pulse),
  .bus_idle(bus_idle), .sda_pull(sda_pull)
);

// File: tb/twi_bus_frontend_tb.sv
module twi_bus_frontend_tb;
  localparam int S = 3;
  localparam int H = 6;
  localparam int SETTLE = S + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_pin = 1'b1, sda_pin = 1'b1, sda_drive_req = 1'b0;
  logic scl_level, sda_level, scl_rise, scl_fall;
  logic start_pulse, stop_pulse, bus_idle, sda_pull;

  int n_chk = 0, n_bad = 0;
  int n_rise = 0, n_fall = 0, n_start = 0, n_stop = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twi_bus_frontend #(.SPIKE_CYC(S), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .sda_drive_req(sda_drive_req), .scl_level(scl_level), .sda_level(sda_level),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .bus_idle(bus_idle), .sda_pull(sda_pull)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      n_rise  += int'(scl_rise);
      n_fall  += int'(scl_fall);
      n_start += int'(start_pulse);
      n_stop  += int'(stop_pulse);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int k, r0, f0, s0, p0;
    cyc(4);
    check({scl_level, sda_level, bus_idle} == 3'b111, "R1 levels/idle in reset",
          int'({scl_level, sda_level, bus_idle}), 7);
    rst_n = 1'b1;
    cyc(1);
    check({scl_rise, scl_fall, start_pulse, stop_pulse, sda_pull} == 5'b0,
          "R1 strobes after reset",
          int'({scl_rise, scl_fall, start_pulse, stop_pulse, sda_pull}), 0);
    check({scl_level, sda_level, bus_idle} == 3'b111, "R1 levels after reset",
          int'({scl_level, sda_level, bus_idle}), 7);

    // R10: follow outside hold window
    sda_drive_req = 1'b1;
    cyc(1);
    check(sda_pull == 1'b1, "R10 follow set", int'(sda_pull), 1);
    sda_drive_req = 1'b0;
    cyc(1);
    check(sda_pull == 1'b0, "R10 follow clear", int'(sda_pull), 0);

    // R2/R3/R4 sweep on SCL
    for (int w = 1; w <= S + 3; w++) begin
      int acc;
      acc = (w >= S + 1) ? 1 : 0;
      r0 = n_rise; f0 = n_fall; s0 = n_start; p0 = n_stop;
      scl_pin = 1'b0;
      cyc(w);
      scl_pin = 1'b1;
      cyc(2 * SETTLE);
      check(n_fall - f0 == acc, $sformatf("R2/R3 scl pulse w=%0d falls", w), n_fall - f0, acc);
      check(n_rise - r0 == acc, $sformatf("R2/R3 scl pulse w=%0d rises", w), n_rise - r0, acc);
      check(n_start == s0 && n_stop == p0, "R7 no start/stop on scl pulse",
            n_start - s0 + n_stop - p0, 0);
    end

    // R2/R3/R5/R6 sweep on SDA with SCL high
    for (int w = 1; w <= S + 3; w++) begin
      int acc;
      acc = (w >= S + 1) ? 1 : 0;
      s0 = n_start; p0 = n_stop;
      sda_pin = 1'b0;
      cyc(w);
      sda_pin = 1'b1;
      cyc(2 * SETTLE);
      check(n_start - s0 == acc, $sformatf("R2/R3/R5 sda pulse w=%0d starts", w), n_start - s0, acc);
      check(n_stop - p0 == acc, $sformatf("R2/R3/R6 sda pulse w=%0d stops", w), n_stop - p0, acc);
      check(bus_idle == 1'b1, "R8 idle after stop", int'(bus_idle), 1);
    end

    // R3/R5/R8 start latency
    sda_pin = 1'b0;
    k = 0;
    while (sda_level && k < 50) begin cyc(1); k++; end
    check(k == S + 3, "R3 sda latency", k, S + 3);
    check(start_pulse == 1'b1, "R5 start with level", int'(start_pulse), 1);
    check(bus_idle == 1'b1, "R8 idle still set in start cycle", int'(bus_idle), 1);
    cyc(1);
    check(start_pulse == 1'b0, "R5 start one cycle", int'(start_pulse), 0);
    check(bus_idle == 1'b0, "R8 idle cleared", int'(bus_idle), 0);

    // R4 scl fall latency
    scl_pin = 1'b0;
    k = 0;
    while (scl_level && k < 50) begin cyc(1); k++; end
    check(k == S + 3, "R3 scl latency", k, S + 3);
    check(scl_fall == 1'b1, "R4 fall strobe", int'(scl_fall), 1);
    cyc(1);
    check(scl_fall == 1'b0, "R4 fall one cycle", int'(scl_fall), 0);

    // R7 data toggles with SCL low
    s0 = n_start; p0 = n_stop;
    sda_pin = 1'b1; cyc(SETTLE);
    sda_pin = 1'b0; cyc(SETTLE);
    sda_pin = 1'b1; cyc(SETTLE);
    check(n_start == s0 && n_stop == p0, "R7 no start/stop with scl low",
          n_start - s0 + n_stop - p0, 0);
    check(bus_idle == 1'b0, "R8 idle unchanged", int'(bus_idle), 0);
    sda_pin = 1'b0; cyc(SETTLE);

    // R4 scl rise
    scl_pin = 1'b1;
    k = 0;
    while (!scl_level && k < 50) begin cyc(1); k++; end
    check(k == S + 3 && scl_rise == 1'b1, "R4 rise strobe", k, S + 3);
    cyc(1);
    check(scl_rise == 1'b0, "R4 rise one cycle", int'(scl_rise), 0);

    // R6/R8 stop
    sda_pin = 1'b1;
    k = 0;
    while (!sda_level && k < 50) begin cyc(1); k++; end
    check(stop_pulse == 1'b1 && k == S + 3, "R6 stop with level", k, S + 3);
    cyc(1);
    check(stop_pulse == 1'b0, "R6 stop one cycle", int'(stop_pulse), 0);
    check(bus_idle == 1'b1, "R8 idle set", int'(bus_idle), 1);

    // R9/R10 hold window sweep
    for (int d = 0; d <= H + 3; d++) begin
      int first, expv;
      expv = ((d > H + 1) ? d : H + 1) + 1;
      scl_pin = 1'b0;
      k = 0;
      while (!scl_fall && k < 50) begin cyc(1); k++; end
      first = 0;
      if (d == 0) sda_drive_req = 1'b1;
      for (int j = 1; j <= H + 8; j++) begin
        cyc(1);
        if (sda_pull && first == 0) first = j;
        if (j == d) sda_drive_req = 1'b1;
      end
      check(first == expv, $sformatf("R9/R10 hold d=%0d", d), first, expv);
      scl_pin = 1'b1;
      sda_drive_req = 1'b0;
      cyc(2 * SETTLE + H + 4);
      check(sda_pull == 1'b0, "R10 release", int'(sda_pull), 0);
    end

    done = 1'b1;
    summary();
  end
endmodule